// File: doc/BRIEF.md
# Sleep power-gating controller

This always-on controller takes power away from a processor core when software asks for it, and brings power back later. Before it sleeps, software uses a small register interface in the core clock domain to set how long the core should stay off and how long reset should be held after power returns. It then writes a sleep command. The controller turns off the enable of an external power switch and asserts core reset. It then waits in a separate slow clock domain for one of two things: an external wake pin, or the expiry of a countdown.

Core state is not retained while the core is off, so every wake is a cold start. Power returns first. Core reset stays asserted for a programmed number of slow cycles so the supply can settle. Reset is then released and the core reboots. A status field records which event caused the last wake.

Top module: `pgate_ctrl`

## Requirements
- R1: After reset, `pwr_en` is 1, `core_rst` is 0 and the status field reads 0.
- R2: A write to address 0 sets the sleep count N, and a write to address 1 sets the settle count H. Both read back unchanged at the same addresses.
- R3: Sleep is entered only through a write to address 2 with bit 0 set. A write to address 2 with bit 0 clear does not change `pwr_en`, and neither does a write to any other address.
- R4: When sleep is entered, `pwr_en` falls and `core_rst` rises on the same slow-clock edge. While `pwr_en` is 0, `core_rst` is 1.
- R5: With no wake pin, `pwr_en` stays 0 for exactly N+1 slow-clock cycles. An N of 0 therefore gives a single off cycle.
- R6: If `wake_pin` goes high between two slow edges while the core is off, `pwr_en` returns to 1 on the third slow rising edge after that point.
- R7: `wake_pin` has no effect while the core is running.
- R8: If the wake pin and counter expiry happen in the same cycle, the pin wins.
- R9: After power returns, `core_rst` stays 1 for exactly H+1 slow-clock cycles and then goes to 0.
- R10: Address 3 reads the wake source in bits [1:0]: 01 means the pin caused the wake and 10 means the counter expired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core-side register clock |
| slow_clk | input | 1 | Always-on slow clock for the counters and sequencing |
| rst | input | 1 | Synchronous active-high reset, sampled in both domains |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| wake_pin | input | 1 | Asynchronous external wake request, active high |
| pwr_en | output | 1 | Enable for the external core power switch |
| core_rst | output | 1 | Core reset, active high |

## Verification
All sleep timing is measured in the slow domain. The bench samples on the slow falling edge. It takes off time as the number of samples with `pwr_en` low, which must be N+1, and settle time as the number of samples with power on and reset still held, which must be H+1. For a pin wake, the bench raises the pin just after a falling edge. It then checks that `pwr_en` is still low after the first and second rising edges and high after the third, which counts two synchronizer flops and the state register. The request crossing adds a variable number of cycles, so the bench waits up to a bounded number of slow cycles for sleep to begin. For ignored commands it waits well past that bound before it checks that power is still on.

// File: rtl/pgate_pkg.sv
package pgate_pkg;

    localparam int DATA_W = 32;

    localparam logic [1:0] ADDR_SLEEP_CNT  = 2'd0;
    localparam logic [1:0] ADDR_SETTLE_CNT = 2'd1;
    localparam logic [1:0] ADDR_COMMAND    = 2'd2;
    localparam logic [1:0] ADDR_STATUS     = 2'd3;

    typedef enum logic [1:0] {
        PS_RUN    = 2'd0,
        PS_OFF    = 2'd1,
        PS_SETTLE = 2'd2
    } pstate_e;

    typedef enum logic [1:0] {
        WS_NONE  = 2'b00,
        WS_PIN   = 2'b01,
        WS_TIMER = 2'b10
    } wsrc_e;

    typedef struct packed {
        logic pwr_en;
        logic core_rst;
    } pout_t;

    function automatic pout_t decode_outputs(pstate_e s);
        pout_t o;
        o.pwr_en   = (s != PS_OFF);
        o.core_rst = (s != PS_RUN);
        return o;
    endfunction

endpackage

// File: rtl/pgate_sync.sv
module pgate_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/pgate_regs.sv
module pgate_regs
    import pgate_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_we,
    input  logic [1:0]          reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic [1:0]          status_core,
    output logic [CNT_W-1:0]    sleep_cnt,
    output logic [SETTLE_W-1:0] settle_cnt,
    output logic                req_tgl
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sleep_cnt  <= '0;
            settle_cnt <= '0;
            req_tgl    <= 1'b0;
        end else if (reg_we) begin
            case (reg_addr)
                ADDR_SLEEP_CNT:  sleep_cnt  <= reg_wdata[CNT_W-1:0];
                ADDR_SETTLE_CNT: settle_cnt <= reg_wdata[SETTLE_W-1:0];
                ADDR_COMMAND:    if (reg_wdata[0]) req_tgl <= ~req_tgl;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (reg_addr)
            ADDR_SLEEP_CNT:  reg_rdata = DATA_W'(sleep_cnt);
            ADDR_SETTLE_CNT: reg_rdata = DATA_W'(settle_cnt);
            ADDR_STATUS:     reg_rdata = DATA_W'(status_core);
            default:         reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pgate_seq.sv
module pgate_seq
    import pgate_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int SETTLE_W = 8
) (
    input  logic                slow_clk,
    input  logic                rst,
    input  logic                req_evt,
    input  logic                wake_s,
    input  logic [CNT_W-1:0]    sleep_cnt,
    input  logic [SETTLE_W-1:0] settle_cnt,
    output logic                pwr_en,
    output logic                core_rst,
    output wsrc_e               wake_src
);
    pstate_e             state;
    logic [CNT_W-1:0]    off_left;
    logic [SETTLE_W-1:0] settle_left;
    pout_t               outs;

    always_ff @(posedge slow_clk) begin
        if (rst) begin
            state       <= PS_RUN;
            off_left    <= '0;
            settle_left <= '0;
            wake_src    <= WS_NONE;
        end else begin
            case (state)
                PS_RUN: if (req_evt) begin
                    state    <= PS_OFF;
                    off_left <= sleep_cnt;
                end
                PS_OFF: begin
                    if (wake_s) begin
                        state       <= PS_SETTLE;
                        settle_left <= settle_cnt;
                        wake_src    <= WS_PIN;
                    end else if (off_left == '0) begin
                        state       <= PS_SETTLE;
                        settle_left <= settle_cnt;
                        wake_src    <= WS_TIMER;
                    end else begin
                        off_left <= off_left - 1'b1;
                    end
                end
                PS_SETTLE: begin
                    if (settle_left == '0) state <= PS_RUN;
                    else settle_left <= settle_left - 1'b1;
                end
                default: state <= PS_RUN;
            endcase
        end
    end

    assign outs     = decode_outputs(state);
    assign pwr_en   = outs.pwr_en;
    assign core_rst = outs.core_rst;

    AST_RUN_STAYS: assert property (@(posedge slow_clk) disable iff (rst)
        (state == PS_RUN && !req_evt) |=> pwr_en && !core_rst); // R3
    AST_OFF_IN_RESET: assert property (@(posedge slow_clk) disable iff (rst)
        !pwr_en |-> core_rst); // R4
    AST_TIMER_WAKE: assert property (@(posedge slow_clk) disable iff (rst)
        (state == PS_OFF && !wake_s && off_left == '0) |=> pwr_en && wake_src == WS_TIMER); // R5
    AST_PIN_WINS: assert property (@(posedge slow_clk) disable iff (rst)
        (state == PS_OFF && wake_s) |=> pwr_en && wake_src == WS_PIN); // R8
    AST_SETTLE_HOLD: assert property (@(posedge slow_clk) disable iff (rst)
        (state == PS_SETTLE && settle_left != '0) |=> core_rst && pwr_en); // R9
    AST_POWER_UP_IN_RESET: assert property (@(posedge slow_clk) disable iff (rst)
        $rose(pwr_en) |-> core_rst); // R9
endmodule

// File: rtl/pgate_ctrl.sv
module pgate_ctrl
    import pgate_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int SETTLE_W = 8
) (
    input  logic        clk,
    input  logic        slow_clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        wake_pin,
    output logic        pwr_en,
    output logic        core_rst
);
    logic [CNT_W-1:0]    sleep_cnt;
    logic [SETTLE_W-1:0] settle_cnt;
    logic                req_tgl, req_s, req_q, req_evt;
    logic                wake_s;
    wsrc_e               wake_src;
    logic [1:0]          status_core;

    pgate_regs #(.CNT_W(CNT_W), .SETTLE_W(SETTLE_W)) u_regs (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .status_core(status_core),
        .sleep_cnt(sleep_cnt), .settle_cnt(settle_cnt), .req_tgl(req_tgl)
    );

    pgate_sync #(.W(1)) u_req_sync (
        .clk(slow_clk), .rst(rst), .d(req_tgl), .q(req_s)
    );

    always_ff @(posedge slow_clk) begin
        if (rst) req_q <= 1'b0;
        else     req_q <= req_s;
    end
    assign req_evt = req_s ^ req_q;

    pgate_sync #(.W(1)) u_wake_sync (
        .clk(slow_clk), .rst(rst), .d(wake_pin), .q(wake_s)
    );

    pgate_seq #(.CNT_W(CNT_W), .SETTLE_W(SETTLE_W)) u_seq (
        .slow_clk(slow_clk), .rst(rst), .req_evt(req_evt), .wake_s(wake_s),
        .sleep_cnt(sleep_cnt), .settle_cnt(settle_cnt),
        .pwr_en(pwr_en), .core_rst(core_rst), .wake_src(wake_src)
    );

    pgate_sync #(.W(2)) u_status_sync (
        .clk(clk), .rst(rst), .d(wake_src), .q(status_core)
    );
endmodule

// File: tb/pgate_ctrl_tb.sv
module pgate_ctrl_tb;
    logic        clk = 1'b0, slow_clk = 1'b0, rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        wake_pin = 1'b0;
    logic        pwr_en, core_rst;
    int          checks = 0, fails = 0;
    bit          done = 0;

    always #4 clk = ~clk;
    always #16 slow_clk = ~slow_clk;

    pgate_ctrl u_dut (
        .clk(clk), .slow_clk(slow_clk), .rst(rst), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .wake_pin(wake_pin), .pwr_en(pwr_en), .core_rst(core_rst)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic slow_step();
        @(posedge slow_clk);
        @(negedge slow_clk);
    endtask

    task automatic wait_off(input string tag);
        int n = 0;
        @(negedge slow_clk);
        while (pwr_en && n < 10) begin slow_step(); n++; end
        check(!pwr_en, tag, int'(pwr_en), 0);
        check(core_rst, {tag, " reset with power off"}, int'(core_rst), 1);
    endtask

    task automatic measure(output int off_n, output int settle_n);
        off_n = 0; settle_n = 0;
        while (!pwr_en && off_n < 5000) begin off_n++; slow_step(); end
        while (core_rst && settle_n < 5000) begin settle_n++; slow_step(); end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check(pwr_en == 1'b1, "R1 pwr_en", int'(pwr_en), 1);
        check(core_rst == 1'b0, "R1 core_rst", int'(core_rst), 0);
        rd(2'd3, d);
        check(d == 0, "R1 status", int'(d), 0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        wr(2'd0, 32'd1234); wr(2'd1, 32'd77);
        rd(2'd0, d); check(d == 1234, "R2 sleep count", int'(d), 1234);
        rd(2'd1, d); check(d == 77, "R2 settle count", int'(d), 77);
    endtask

    task automatic t_ignored_cmds();
        wr(2'd2, 32'd0);
        wr(2'd0, 32'd5);
        wr(2'd1, 32'd1);
        repeat (12) slow_step();
        check(pwr_en == 1'b1, "R3 no sleep without bit0", int'(pwr_en), 1);
        wake_pin = 1'b1;
        repeat (8) slow_step();
        check(pwr_en && !core_rst, "R7 pin while running", int'(pwr_en), 1);
        wake_pin = 1'b0;
        repeat (4) slow_step();
    endtask

    task automatic t_timer(input int n, input int h);
        int off_n, settle_n;
        logic [31:0] d;
        wr(2'd0, n); wr(2'd1, h);
        wr(2'd2, 32'd1);
        wait_off("R4 sleep entry");
        measure(off_n, settle_n);
        check(off_n == n + 1, "R5 off cycles", off_n, n + 1);
        check(settle_n == h + 1, "R9 settle cycles", settle_n, h + 1);
        check(pwr_en && !core_rst, "R9 released", int'(core_rst), 0);
        repeat (4) slow_step();
        rd(2'd3, d);
        check(d == 2, "R10 timer source", int'(d), 2);
    endtask

    task automatic t_pin();
        int off_n, settle_n;
        logic [31:0] d;
        wr(2'd0, 1000); wr(2'd1, 3);
        wr(2'd2, 32'd1);
        wait_off("R4 sleep entry pin");
        wake_pin = 1'b1;
        slow_step(); check(!pwr_en, "R6 edge 1", int'(pwr_en), 0);
        slow_step(); check(!pwr_en, "R6 edge 2", int'(pwr_en), 0);
        slow_step(); check(pwr_en, "R6 edge 3", int'(pwr_en), 1);
        wake_pin = 1'b0;
        measure(off_n, settle_n);
        check(settle_n == 4, "R9 settle after pin", settle_n, 4);
        repeat (4) slow_step();
        rd(2'd3, d);
        check(d == 1, "R10 pin source", int'(d), 1);
    endtask

    task automatic t_priority();
        int off_n, settle_n;
        logic [31:0] d;
        wr(2'd0, 0); wr(2'd1, 0);
        wake_pin = 1'b1;
        repeat (4) slow_step();
        wr(2'd2, 32'd1);
        wait_off("R4 sleep entry prio");
        measure(off_n, settle_n);
        wake_pin = 1'b0;
        check(off_n == 1, "R8 off cycles", off_n, 1);
        repeat (4) slow_step();
        rd(2'd3, d);
        check(d == 1, "R8 pin beats timer", int'(d), 1);
    endtask

    initial begin
        repeat (6) @(posedge slow_clk);
        @(negedge clk) rst = 1'b0;
        @(negedge slow_clk);
        t_reset();
        t_regs();
        t_ignored_cmds();
        t_timer(3, 2);
        t_timer(0, 0);
        t_pin();
        t_priority();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule